// File: doc/BRIEF.md
# Next Instruction Address Generator

This block holds the program counter of a 32-bit load/store processor and works out, every cycle, the address that the fetch stage uses next. It computes three candidate addresses in parallel from the current counter and the fetched instruction word: the fall-through address four bytes on, a PC-relative branch destination, and an absolute jump destination. A priority selector then picks one of these or a full register value supplied by the decode stage. The taken/not-taken result of the branch comparison comes in as an input. The block does not compare registers itself.

The selection is built as a small source-select decision with four named outcomes. SRC_SEQ is the fall-through path, taken when no redirect applies. SRC_BRANCH is taken when a conditional branch is decoded and its test holds. SRC_JUMP is an absolute jump. SRC_REG is a jump through a register. The decision is recomputed every cycle. The counter register loads the chosen address on each rising edge. A synchronous reset overrides that load, and so does a hold input that repeats the current fetch during a pipeline stall.

Top module: `npc_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0x00000000 on that edge, whatever `hold` or the redirect inputs are.
- R2: When none of `jr_en`, `jmp_en` and (`br_en` and `br_taken`) is active, `pc_next` equals `pc` + 4, wrapping modulo 2^32.
- R3: `br_target` always equals (`pc` + 4) + (instruction bits 15..0 sign-extended to 32 bits and shifted left by 2), wrapping modulo 2^32, independent of any select input.
- R4: With `br_en` high and `br_taken` high, and no jump active, `pc_next` equals `br_target`. With `br_en` high and `br_taken` low, `pc_next` is `pc` + 4. `br_taken` has no effect while `br_en` is low.
- R5: With `jmp_en` high and `jr_en` low, `pc_next` is bits 31..28 of (`pc` + 4) in bits 31..28, instruction bits 25..0 in bits 27..2, and zeros in bits 1..0.
- R6: With `jr_en` high, `pc_next` equals the full 32-bit `jr_addr`.
- R7: When several redirects are active, the register jump wins over the absolute jump, and the absolute jump wins over a taken branch.
- R8: When `hold` is high and `rst` is low at a rising edge, `pc` keeps its value across that edge.
- R9: When `rst` and `hold` are both low at a rising edge, `pc` takes the value that `pc_next` had just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Stall: keep the current counter value |
| instr | input | 32 | Fetched instruction word |
| br_en | input | 1 | Decoded conditional branch |
| br_taken | input | 1 | Branch test result (true = redirect) |
| jmp_en | input | 1 | Decoded absolute jump |
| jr_en | input | 1 | Decoded register-indirect jump |
| jr_addr | input | 32 | Register value used as the indirect target |
| pc | output | 32 | Current program counter |
| pc_next | output | 32 | Address loaded at the next unstalled edge |
| br_target | output | 32 | Computed PC-relative branch destination |

## Verification
The bound checker checks the following on every cycle: the reset value, the counter freeze under hold, and that the counter follows `pc_next` on unstalled edges. It also checks the fall-through arithmetic, the branch-target arithmetic and the register-jump override. The table-driven bench covers the rest. This includes the jump-splice bit layout where the upper counter bits are non-zero, and negative branch offsets. It also covers wrap-around past the top of the address space and the priority order when several redirects arrive together. Finally, it checks that a branch result without a decoded branch changes nothing, and that reset overrides a simultaneous hold.

// File: rtl/npc_pkg.sv
package npc_pkg;
    // Source of the next fetch address.
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2,
        SRC_REG    = 2'd3
    } npc_src_e;
endpackage

// File: rtl/npc_targets.sv
module npc_targets #(
    parameter int ADDR_W  = 32,
    parameter int INSTR_W = 32,
    parameter int OFF_W   = 16,
    parameter int IDX_W   = 26,
    parameter int STEP    = 4
) (
    input  logic [ADDR_W-1:0]  pc,
    input  logic [INSTR_W-1:0] instr,
    output logic [ADDR_W-1:0]  seq_addr,
    output logic [ADDR_W-1:0]  br_addr,
    output logic [ADDR_W-1:0]  jmp_addr
);
    localparam int SHIFT = $clog2(STEP);
    localparam int EXT_W = ADDR_W - OFF_W - SHIFT;
    localparam int UP_W  = ADDR_W - IDX_W - SHIFT;

    logic [OFF_W-1:0]  offset;
    logic [IDX_W-1:0]  index;
    logic [ADDR_W-1:0] byte_off;

    always_comb begin
        offset   = instr[OFF_W-1:0];
        index    = instr[IDX_W-1:0];
        seq_addr = pc + ADDR_W'(STEP);
        byte_off = {{EXT_W{offset[OFF_W-1]}}, offset, {SHIFT{1'b0}}};
        br_addr  = seq_addr + byte_off;
        jmp_addr = {seq_addr[ADDR_W-1 -: UP_W], index, {SHIFT{1'b0}}};
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              br_en,
    input  logic              br_taken,
    input  logic              jmp_en,
    input  logic              jr_en,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [ADDR_W-1:0] br_addr,
    input  logic [ADDR_W-1:0] jmp_addr,
    input  logic [ADDR_W-1:0] jr_addr,
    output npc_src_e          src,
    output logic [ADDR_W-1:0] next_addr
);
    // Priority decision: register jump, then jump, then taken branch.
    always_comb begin
        if (jr_en)                   src = SRC_REG;
        else if (jmp_en)             src = SRC_JUMP;
        else if (br_en && br_taken)  src = SRC_BRANCH;
        else                         src = SRC_SEQ;
    end

    always_comb begin
        unique case (src)
            SRC_SEQ:    next_addr = seq_addr;
            SRC_BRANCH: next_addr = br_addr;
            SRC_JUMP:   next_addr = jmp_addr;
            SRC_REG:    next_addr = jr_addr;
            default:    next_addr = seq_addr;
        endcase
    end
endmodule

// File: rtl/npc_gen.sv
module npc_gen
    import npc_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          INSTR_W   = 32,
    parameter int          OFF_W     = 16,
    parameter int          IDX_W     = 26,
    parameter int          STEP      = 4,
    parameter logic [31:0] RESET_VAL = 32'h0000_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic [INSTR_W-1:0] instr,
    input  logic               br_en,
    input  logic               br_taken,
    input  logic               jmp_en,
    input  logic               jr_en,
    input  logic [ADDR_W-1:0]  jr_addr,
    output logic [ADDR_W-1:0]  pc,
    output logic [ADDR_W-1:0]  pc_next,
    output logic [ADDR_W-1:0]  br_target
);
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] jmp_addr;
    npc_src_e          src;

    npc_targets #(
        .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .OFF_W(OFF_W),
        .IDX_W(IDX_W), .STEP(STEP)
    ) u_targets (
        .pc       (pc),
        .instr    (instr),
        .seq_addr (seq_addr),
        .br_addr  (br_target),
        .jmp_addr (jmp_addr)
    );

    npc_select #(.ADDR_W(ADDR_W)) u_select (
        .br_en     (br_en),
        .br_taken  (br_taken),
        .jmp_en    (jmp_en),
        .jr_en     (jr_en),
        .seq_addr  (seq_addr),
        .br_addr   (br_target),
        .jmp_addr  (jmp_addr),
        .jr_addr   (jr_addr),
        .src       (src),
        .next_addr (pc_next)
    );

    always_ff @(posedge clk) begin
        if (rst)        pc <= RESET_VAL[ADDR_W-1:0];
        else if (!hold) pc <= pc_next;
    end
endmodule

// File: rtl/npc_gen_chk.sv
module npc_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              hold,
    input logic [31:0]       instr,
    input logic              br_en,
    input logic              br_taken,
    input logic              jmp_en,
    input logic              jr_en,
    input logic [ADDR_W-1:0] jr_addr,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] pc_next,
    input logic [ADDR_W-1:0] br_target
);
    logic [ADDR_W-1:0] exp_off;
    assign exp_off = ADDR_W'({{16{instr[15]}}, instr[15:0]}) << 2;

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> pc == '0);

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!jr_en && !jmp_en && !(br_en && br_taken)) |-> pc_next == pc + ADDR_W'(4));

    assert_branch_target_R3: assert property (@(posedge clk) disable iff (rst)
        br_target == pc + ADDR_W'(4) + exp_off);

    assert_reg_jump_R6: assert property (@(posedge clk) disable iff (rst)
        jr_en |-> pc_next == jr_addr);

    assert_hold_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        (hold && !rst) |=> pc == $past(pc));

    assert_follow_next_R9: assert property (@(posedge clk) disable iff (rst)
        (!hold && !rst) |=> pc == $past(pc_next));
endmodule

bind npc_gen npc_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .hold(hold), .instr(instr),
    .br_en(br_en), .br_taken(br_taken), .jmp_en(jmp_en), .jr_en(jr_en),
    .jr_addr(jr_addr), .pc(pc), .pc_next(pc_next), .br_target(br_target)
);

// File: tb/sim_npc_gen.sv
module sim_npc_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hold = 1'b0;
    logic [31:0] instr = '0;
    logic        br_en = 1'b0, br_taken = 1'b0, jmp_en = 1'b0, jr_en = 1'b0;
    logic [31:0] jr_addr = '0;
    logic [31:0] pc, pc_next, br_target;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    npc_gen u0 (
        .clk(clk), .rst(rst), .hold(hold), .instr(instr),
        .br_en(br_en), .br_taken(br_taken), .jmp_en(jmp_en), .jr_en(jr_en),
        .jr_addr(jr_addr), .pc(pc), .pc_next(pc_next), .br_target(br_target)
    );

    // Vector layout: {hold, jr_en, jmp_en, br_en, br_taken, instr[31:0], jr_addr[31:0]}
    localparam int NV = 14;
    localparam logic [68:0] VEC [NV] = '{
        {5'b00000, 32'h0000_0000, 32'h0},           // fall-through
        {5'b00011, 32'h1000_0003, 32'h0},           // branch taken, +3 words
        {5'b00010, 32'h1000_FFF0, 32'h0},           // branch not taken
        {5'b00001, 32'h1000_FFFF, 32'h0},           // taken flag without branch
        {5'b00011, 32'h1400_FFFE, 32'h0},           // branch taken, -2 words
        {5'b00100, 32'h0800_0040, 32'h0},           // jump
        {5'b10100, 32'h0800_0123, 32'h0},           // hold with a jump pending
        {5'b01000, 32'h0000_0000, 32'hF000_0010},   // register jump
        {5'b00100, 32'h0BFF_FFFF, 32'h0},           // jump keeps upper bits
        {5'b00000, 32'h0000_0000, 32'h0},           // wrap past top
        {5'b01111, 32'h0800_0010, 32'h0000_0800},   // all redirects
        {5'b00111, 32'h0800_0010, 32'h0},           // jump beats branch
        {5'b00011, 32'h1000_7FFF, 32'h0},           // max positive offset
        {5'b00011, 32'h1000_8000, 32'h0}            // max negative offset
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Independent model of the next address, from the requirements.
    function automatic logic [31:0] model_next(input logic [31:0] p, input logic [68:0] v,
                                               output string tag);
        logic [31:0] inc, brt;
        inc = p + 32'd4;
        brt = inc + ({{16{v[47]}}, v[47:32]} * 32'd4);
        if (v[67] && (v[66] || v[65])) begin tag = "R7"; return v[31:0]; end
        if (v[67])                     begin tag = "R6"; return v[31:0]; end
        if (v[66] && v[65] && v[64])   begin tag = "R7"; return {inc[31:28], v[57:32], 2'b00}; end
        if (v[66])                     begin tag = "R5"; return {inc[31:28], v[57:32], 2'b00}; end
        if (v[65] && v[64])            begin tag = "R4"; return brt; end
        if (v[65] || v[64])            begin tag = "R4"; return inc; end
        tag = "R2";
        return inc;
    endfunction

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] exp_pc;
        string tag;
        repeat (2) @(negedge clk);
        check("R1 reset value", pc, 32'h0);
        rst = 1'b0;
        exp_pc = 32'h0;
        for (int i = 0; i < NV; i++) begin
            logic [31:0] nxt;
            {hold, jr_en, jmp_en, br_en, br_taken, instr, jr_addr} = VEC[i];
            nxt = model_next(exp_pc, VEC[i], tag);
            #2;
            check({tag, " next address"}, pc_next, nxt);
            check("R3 branch target", br_target,
                  exp_pc + 32'd4 + ({{16{instr[15]}}, instr[15:0]} * 32'd4));
            @(negedge clk);
            if (VEC[i][68]) begin
                check("R8 hold keeps pc", pc, exp_pc);
            end else begin
                exp_pc = nxt;
                check("R9 pc follows next", pc, exp_pc);
            end
        end
        // Reset overrides hold and redirects.
        {hold, jr_en, jmp_en, br_en, br_taken} = 5'b11000;
        jr_addr = 32'h1234_5678;
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset over hold", pc, 32'h0);
        rst = 1'b0;
        hold = 1'b0;
        @(negedge clk);
        check("R6 register jump after reset", pc, 32'h1234_5678);
        jr_en = 1'b0;
        // Two held cycles in a row, then release.
        hold = 1'b1;
        @(negedge clk);
        check("R8 first hold", pc, 32'h1234_5678);
        @(negedge clk);
        check("R8 second hold", pc, 32'h1234_5678);
        hold = 1'b0;
        @(negedge clk);
        check("R2 step after hold", pc, 32'h1234_567C);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule